// File: doc/BRIEF.md
# Serial Receive Channel with Line Status

This block is the receive half of an asynchronous serial port. It watches a serial input line with a sampling enable that pulses sixteen times per bit period. When the line falls, the block waits half a bit and checks that the line is still low, which confirms a real start bit. It then collects five to eight data bits, least significant first, followed by an optional parity bit and one stop bit.

Each completed character goes from the shift register into a single holding register, which the CPU reads. An eight-bit line status word reports whether data is waiting and whether an overrun, a parity error, a framing error or a line break was seen. Reading the holding register clears the data-waiting flag. Reading the status clears the error and break flags.

The block also detects a line break. If the line stays low for a whole character, it loads a zero character and raises the break flag. It then waits for the line to return high before it looks for the next start bit.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `rx_data` is 0x00 and `line_status` is 0x00.
- R2: A frame is a low start bit, then N data bits least significant first, then an optional parity bit, then a stop bit. N is 5, 6, 7 or 8 for `cfg_len` 00, 01, 10 or 11. A character appears on `rx_data` with its unused upper bits zero, and `line_status` bit 0 (data ready) sets.
- R3: The start bit is confirmed at the eighth sampling tick after the falling edge is first seen. A low pulse that is gone by then is rejected: no character is loaded, and the receiver is ready for the next frame.
- R4: With `cfg_par_en` high, a parity bit follows the data. `cfg_par_even` = 1 means the data bits plus the parity bit hold an even number of ones, and 0 means an odd number. A mismatch sets `line_status` bit 2.
- R5: A stop bit sampled low sets `line_status` bit 3. The character is still loaded and data ready still sets.
- R6: If the line is low for every bit position of a frame (start, data, parity if enabled, and stop), the block loads 0x00 and sets `line_status` bit 4. Bits 2 and 3 are not set for that character. No new start bit is accepted until the line has been high.
- R7: If a character completes while data ready is still set, `line_status` bit 1 (overrun) sets and the new character replaces the old one.
- R8: Pulsing `rd_data` clears bit 0. Pulsing `rd_status` clears bits 1 to 4 and leaves bit 0 alone. A character that completes in the same cycle takes priority over either clear.
- R9: `line_status` bits 5 to 7 always read 0. Bits 5 and 6 are kept for a transmit path that is not part of this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sampling enable, sixteen pulses per bit period |
| rx_line | input | 1 | Serial input line, idles high |
| cfg_len | input | 2 | Data length code (00=5, 01=6, 10=7, 11=8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 for even parity, 0 for odd |
| rd_data | input | 1 | One-cycle pulse: CPU read of the holding register |
| rd_status | input | 1 | One-cycle pulse: CPU read of the line status |
| rx_data | output | 8 | Holding register contents |
| line_status | output | 8 | Status bits: ready, overrun, parity, framing, break, zeros |

## Verification
The main tests cover all four data lengths with parity off, even parity and odd parity. A wrong width or a wrong parity sense then shows up as a data miscompare or a spurious parity flag. A frame with a corrupted parity bit and a frame with a low stop bit check that each error sets only its own flag. A short glitch followed by a good frame shows that false starts are rejected and that the receiver recovers afterwards. A held-low line sets the break flag, loads a zero character and produces no second character, which separates break from a framing error. Two frames sent without a read show the overrun flag and the replaced data, and separate reads show which flags each read clears.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PARITY,
      RX_STOP,
      RX_HOLD
   } rx_state_t;

   typedef struct packed {
      logic [7:0] data;
      logic       par_err;
      logic       frm_err;
      logic       brk;
   } rx_char_t;

   localparam int LS_READY   = 0;
   localparam int LS_OVERRUN = 1;
   localparam int LS_PARITY  = 2;
   localparam int LS_FRAME   = 3;
   localparam int LS_BREAK   = 4;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], din} & {STAGES{1'b1}};
         end
         assign dout = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
   import uart_rx_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     rx,
   input  logic [1:0] cfg_len,
   input  logic     cfg_par_en,
   input  logic     cfg_par_even,
   output logic     char_valid,
   output rx_char_t char_out
);
   localparam int CW  = $clog2(OVERSAMPLE);
   localparam int MID = OVERSAMPLE / 2;
   localparam logic [CW-1:0] MID_LAST = CW'(MID - 1);
   localparam logic [CW-1:0] BIT_LAST = CW'(OVERSAMPLE - 1);

   rx_state_t     state;
   logic [CW-1:0] cnt;
   logic [2:0]    bit_idx;
   logic [7:0]    shreg;
   logic          par_acc;
   logic          all_zero;

   logic [2:0] last_idx;
   logic       bit_point;
   assign last_idx  = {1'b0, cfg_len} + 3'd4;
   assign bit_point = tick && (cnt == BIT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         par_acc  <= 1'b0;
         all_zero <= 1'b0;
      end else begin
         case (state)
            RX_IDLE: begin
               if (tick && !rx) begin
                  state <= RX_START;
                  cnt   <= '0;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (cnt == MID_LAST) begin
                     cnt <= '0;
                     if (rx) begin
                        state <= RX_IDLE;
                     end else begin
                        state    <= RX_DATA;
                        bit_idx  <= '0;
                        shreg    <= '0;
                        par_acc  <= 1'b0;
                        all_zero <= 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (bit_point) begin
                  cnt            <= '0;
                  shreg[bit_idx] <= rx;
                  par_acc        <= par_acc ^ rx;
                  if (rx) all_zero <= 1'b0;
                  if (bit_idx == last_idx) state <= cfg_par_en ? RX_PARITY : RX_STOP;
                  else                     bit_idx <= bit_idx + 1'b1;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_PARITY: begin
               if (bit_point) begin
                  cnt     <= '0;
                  par_acc <= par_acc ^ rx;
                  if (rx) all_zero <= 1'b0;
                  state   <= RX_STOP;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_STOP: begin
               if (bit_point) begin
                  cnt   <= '0;
                  state <= rx ? RX_IDLE : RX_HOLD;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_HOLD: begin
               if (rx) state <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   always_comb begin
      char_valid       = (state == RX_STOP) && bit_point;
      char_out.brk     = all_zero && !rx;
      char_out.frm_err = !rx && !char_out.brk;
      char_out.par_err = cfg_par_en && !char_out.brk && (par_acc ^ !cfg_par_even);
      char_out.data    = char_out.brk ? 8'h00 : shreg;
   end

   assert_valid_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      char_valid |-> tick);

   assert_hold_blocks_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_HOLD && !rx) |=> state != RX_START);
endmodule

// File: rtl/uart_rx_linestat.sv
module uart_rx_linestat
   import uart_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       char_valid,
   input  rx_char_t   char_in,
   input  logic       rd_data,
   input  logic       rd_status,
   output logic [7:0] rx_data,
   output logic [7:0] line_status
);
   logic [7:0] hold_q;
   logic       ready_q, ovr_q, par_q, frm_q, brk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
         par_q   <= 1'b0;
         frm_q   <= 1'b0;
         brk_q   <= 1'b0;
      end else begin
         if (char_valid) hold_q <= char_in.data;

         if (char_valid)   ready_q <= 1'b1;
         else if (rd_data) ready_q <= 1'b0;

         if (char_valid && ready_q && !rd_data) ovr_q <= 1'b1;
         else if (rd_status)                    ovr_q <= 1'b0;

         if (char_valid && char_in.par_err) par_q <= 1'b1;
         else if (rd_status)                par_q <= 1'b0;

         if (char_valid && char_in.frm_err) frm_q <= 1'b1;
         else if (rd_status)                frm_q <= 1'b0;

         if (char_valid && char_in.brk) brk_q <= 1'b1;
         else if (rd_status)            brk_q <= 1'b0;
      end
   end

   always_comb begin
      line_status             = '0;
      line_status[LS_READY]   = ready_q;
      line_status[LS_OVERRUN] = ovr_q;
      line_status[LS_PARITY]  = par_q;
      line_status[LS_FRAME]   = frm_q;
      line_status[LS_BREAK]   = brk_q;
   end
   assign rx_data = hold_q;

   assert_ready_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !char_valid) |=> !line_status[LS_READY]);

   assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !char_valid) |=> line_status[4:1] == 4'b0000);

   assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && line_status[LS_READY] && !rd_data) |=> line_status[LS_OVERRUN]);

   assert_break_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && char_in.brk) |=> (rx_data == 8'h00) && line_status[LS_BREAK]);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_rx_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic       rx_line,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic       cfg_par_even,
   input  logic       rd_data,
   input  logic       rd_status,
   output logic [7:0] rx_data,
   output logic [7:0] line_status
);
   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("uart_rx_core: OVERSAMPLE must be even and at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("uart_rx_core: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic     rx_s;
   logic     char_valid;
   rx_char_t char_w;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_line),
      .dout (rx_s)
   );

   uart_rx_framer #(.OVERSAMPLE(OVERSAMPLE)) u_framer (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick16),
      .rx          (rx_s),
      .cfg_len     (cfg_len),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_even(cfg_par_even),
      .char_valid  (char_valid),
      .char_out    (char_w)
   );

   uart_rx_linestat u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .char_valid (char_valid),
      .char_in    (char_w),
      .rd_data    (rd_data),
      .rd_status  (rd_status),
      .rx_data    (rx_data),
      .line_status(line_status)
   );

   assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_status[0]) |-> line_status[7:5] == 3'b000);
endmodule

// File: tb/uart_rx_core_test.sv
`timescale 1ns/1ps
module uart_rx_core_test;
   localparam int BITCLK = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16;
   logic       rx_line = 1'b1;
   logic [1:0] cfg_len = 2'b11;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_even = 1'b0;
   logic       rd_data = 1'b0;
   logic       rd_status = 1'b0;
   logic [7:0] rx_data;
   logic [7:0] line_status;
   logic [1:0] div = '0;
   logic       auto_read = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] exp_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) div <= div + 1'b1;
   assign tick16 = (div == 2'd0);

   uart_rx_core uut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
      .rd_data(rd_data), .rd_status(rd_status),
      .rx_data(rx_data), .line_status(line_status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic hold_line(input logic v, input int nbits);
      rx_line = v;
      repeat (nbits * BITCLK) @(negedge clk);
   endtask

   // scoreboard driver: sends one frame, optionally queues the expected result
   task automatic send_frame(input logic [7:0] d, input logic [1:0] len, input logic pen,
                             input logic peven, input logic bad_par, input logic stopv,
                             input logic push);
      int nb;
      logic p;
      logic [7:0] m;
      logic [7:0] st;
      nb = 5 + int'(len);
      m = 8'hFF >> (8 - nb);
      cfg_len = len; cfg_par_en = pen; cfg_par_even = peven;
      p = ^(d & m);
      if (!peven) p = ~p;
      if (bad_par) p = ~p;
      st = 8'h01 | ((pen && bad_par) ? 8'h04 : 8'h00) | (!stopv ? 8'h08 : 8'h00);
      if (push) exp_q.push_back({d & m, st});
      hold_line(1'b0, 1);
      for (int i = 0; i < nb; i++) hold_line(d[i], 1);
      if (pen) hold_line(p, 1);
      hold_line(stopv, 1);
      hold_line(1'b1, 2);
   endtask

   // monitor: pops the expected item and compares when data ready appears
   always @(negedge clk) begin
      if (auto_read) begin
         if (rd_data || rd_status) begin
            rd_data <= 1'b0; rd_status <= 1'b0;
         end else if (line_status[0]) begin
            if (exp_q.size() == 0) begin
               chk("R3 unexpected character", {24'h0, rx_data}, 32'hFFFF_FFFF);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk("R2/R4/R5 data", {24'h0, rx_data}, {24'h0, e[15:8]});
               chk("R2/R4/R5/R9 status", {24'h0, line_status}, {24'h0, e[7:0]});
            end
            rd_data <= 1'b1; rd_status <= 1'b1;
         end
      end
   end

   task automatic pulse_read(input logic dat, input logic sts);
      @(negedge clk);
      rd_data = dat; rd_status = sts;
      @(negedge clk);
      rd_data = 1'b0; rd_status = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rx_data after reset", {24'h0, rx_data}, 32'h0);
      chk("R1 line_status after reset", {24'h0, line_status}, 32'h0);
      hold_line(1'b1, 1);

      auto_read = 1'b1;
      send_frame(8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1); // R2 8N1
      send_frame(8'h3F, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1); // R2 5 bits
      send_frame(8'h2D, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1); // R4 6 bits even
      send_frame(8'h55, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1); // R4 7 bits odd
      send_frame(8'hC3, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1); // R4 8 bits odd
      send_frame(8'h81, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1); // R4 parity error
      send_frame(8'h3C, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); // R5 framing error

      // R3 false start: low for a quarter bit only
      cfg_len = 2'b11; cfg_par_en = 1'b0;
      rx_line = 1'b0;
      repeat (BITCLK / 4) @(negedge clk);
      hold_line(1'b1, 3);
      chk("R3 no character after glitch", {31'h0, line_status[0]}, 32'h0);
      send_frame(8'h66, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1); // R3 recovery
      hold_line(1'b1, 1);
      chk("R2 scoreboard drained", exp_q.size(), 32'd0);

      auto_read = 1'b0;
      @(negedge clk);
      // R7 overrun
      send_frame(8'h11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      send_frame(8'h22, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R7 newer data kept", {24'h0, rx_data}, 32'h22);
      chk("R7 overrun flag", {24'h0, line_status}, 32'h03);
      pulse_read(1'b0, 1'b1);
      chk("R8 status read keeps ready", {24'h0, line_status}, 32'h01);
      pulse_read(1'b1, 1'b0);
      chk("R8 data read clears ready", {24'h0, line_status}, 32'h00);

      // R6 break: low across a whole 8N1 frame and beyond
      hold_line(1'b0, 12);
      hold_line(1'b1, 3);
      chk("R6 break zero character", {24'h0, rx_data}, 32'h00);
      chk("R6/R9 break status", {24'h0, line_status}, 32'h11);
      pulse_read(1'b1, 1'b1);
      chk("R8 all cleared after break reads", {24'h0, line_status}, 32'h00);

      // R6 break with parity enabled
      cfg_par_en = 1'b1; cfg_par_even = 1'b1;
      hold_line(1'b0, 13);
      hold_line(1'b1, 3);
      chk("R6 break with parity, no parity error", {24'h0, line_status}, 32'h11);
      pulse_read(1'b1, 1'b1);
      chk("R9 upper bits zero", {29'h0, line_status[7:5]}, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule